// File: doc/BRIEF.md
# Multiline Receive Silo

This block gathers characters from eight serial receive lines into one shared first-in first-out silo. The bit-level receivers sit outside the block. Each receiver hands over a finished character by pulsing its strobe for one cycle, with the data byte and its parity-error and framing-error flags. The block first parks each character in a one-entry holding register for its line. A fixed-priority arbiter then moves one character per cycle into the silo. Each stored entry carries the line number, the error flags and an overrun flag.

A processor reaches the block through a two-address register port. The control/status address holds the scan enable, the receive interrupt enable and the silo-alarm interrupt enable. A write with the clear bit set resets the whole block. A read of the buffer address returns the head entry and pops it. A write to the same buffer address loads the configuration of one line instead. That configuration holds the speed code, the character length, the stop bits and the parity setting. Only the character length acts inside the block. The full configuration word of each line goes out on `lineCfg` for the receivers.

Top module: `rx_silo`

## Requirements
- R1: After reset, a buffer-address read returns 0. Both interrupts are low, every `lineCfg` field is 0, and the control word reads back as 0.
- R2: A buffer word with a character present reads as follows. Bit 15 is 1. Bit 14 is the overrun flag, bit 13 the framing error and bit 12 the parity error. Bit 11 is 0, bits 10:8 hold the line number and bits 7:0 the data. When the silo is empty, the word reads as 0.
- R3: Characters come out in arrival order. Each buffer read with busSel=1 pops exactly one entry. A character strobed before edge N can be read after edge N+1.
- R4: When several lines hold a character in the same cycle, the lowest line number is moved into the silo first.
- R5: Received data is masked to the line's length code, held in configuration bits 1:0 (write bits 4:3). Code 0 keeps 5 bits, 1 keeps 6, 2 keeps 7 and 3 keeps 8.
- R6: A write to the buffer address stores write bits 11:3 as the `lineCfg` field of the line named by write bits 2:0. The fields of all other lines stay unchanged.
- R7: While control bit 5 (scan enable) is 0, receive strobes are ignored and nothing enters the silo.
- R8: The silo holds 64 entries. A character retired while the silo is full is discarded, and the next stored entry gets bit 14 set.
- R9: A second strobe on a line whose previous character is still held replaces that character and sets bit 14 on the new one.
- R10: The silo-alarm condition latches when occupancy reaches 16, and a buffer read clears it. It arms again only after occupancy falls below 16. `alarmIrq` is the latched condition ANDed with control bit 12.
- R11: `rxIrq` is high exactly when control bit 6 is 1 and the silo is not empty.
- R12: A control write with bit 4 set performs a clear. It empties the silo and all holding registers, zeroes every `lineCfg` field and the control bits, and drops any pending overrun and alarm state.
- R13: Control bits 5, 6 and 12 are stored on write and read back in place. All other control read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxStrobe | input | 8 | Per-line character-ready pulse |
| rxData | input | 64 | Per-line received byte, line i in bits 8i+7:8i |
| rxParErr | input | 8 | Per-line parity error flag |
| rxFrmErr | input | 8 | Per-line framing error flag |
| busSel | input | 1 | Register select: 0 control/status, 1 buffer/line configuration |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops the silo when busSel=1) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the selected register |
| rxIrq | output | 1 | Receive interrupt request |
| alarmIrq | output | 1 | Silo-alarm interrupt request |
| lineCfg | output | 72 | Per-line configuration, line i in bits 9i+8:9i |

## Verification
Random single-line bursts of random length use random lines, data and error flags. Each burst is drained and compared word by word with a bench queue. These runs separate correct ordering, tagging and flag placement from swapped or shifted fields. Directed patterns strobe several lines in one cycle, which tells the priority order apart from arrival order. Back-to-back strobes on one line separate a replaced held character from a clean hand-off. Filling the silo to 64 and beyond, and crossing the 16-entry level up and down, shows drop-on-full, overrun tagging and the re-arm rule. A pass with scan enable off and a pass with the clear bit complete the set.

// File: rtl/rx_silo_pkg.sv
`timescale 1ns/1ps
package rx_silo_pkg;

  localparam int LINE_W = 3;
  localparam int DATA_W = 8;
  localparam int CFG_W  = 9;

  // Control strobes from the control module to the datapath
  typedef struct packed {
    logic              clear;
    logic              retire;
    logic              write;
    logic [LINE_W-1:0] line;
    logic              ovr;
    logic              pop;
  } siloCmdT;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
  } siloEntryT;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } holdT;

  function automatic logic [DATA_W-1:0] maskChar(input logic [DATA_W-1:0] d,
                                                 input logic [1:0] lenCode);
    logic [DATA_W-1:0] m;
    case (lenCode)
      2'd0:    m = 8'h1F;
      2'd1:    m = 8'h3F;
      2'd2:    m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return d & m;
  endfunction

endpackage

// File: rtl/rx_silo_dp.sv
`timescale 1ns/1ps
module rx_silo_dp
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  siloCmdT                   cmd,
  input  logic                      captureEn,
  input  logic [NUM_LINES-1:0]      rxStrobe,
  input  logic [NUM_LINES*8-1:0]    rxData,
  input  logic [NUM_LINES-1:0]      rxParErr,
  input  logic [NUM_LINES-1:0]      rxFrmErr,
  input  logic [NUM_LINES*2-1:0]    lenCode,
  output logic [NUM_LINES-1:0]      pendVec,
  output logic [CNT_W-1:0]          count,
  output logic                      full,
  output siloEntryT                 headEntry
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

  holdT              hold [NUM_LINES];
  siloEntryT         mem  [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  siloEntryT         newEntry;

  // Per-line holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVec <= '0;
      for (int i = 0; i < NUM_LINES; i++) hold[i] <= '0;
    end else if (cmd.clear) begin
      pendVec <= '0;
      for (int i = 0; i < NUM_LINES; i++) hold[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (captureEn && rxStrobe[i]) begin
          pendVec[i]   <= 1'b1;
          hold[i].data <= maskChar(rxData[i*8 +: 8], lenCode[i*2 +: 2]);
          hold[i].pe   <= rxParErr[i];
          hold[i].fe   <= rxFrmErr[i];
          hold[i].ovr  <= pendVec[i] && !(cmd.retire && cmd.line == LINE_W'(i));
        end else if (cmd.retire && cmd.line == LINE_W'(i)) begin
          pendVec[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    newEntry      = '0;
    newEntry.ovr  = hold[cmd.line].ovr | cmd.ovr;
    newEntry.fe   = hold[cmd.line].fe;
    newEntry.pe   = hold[cmd.line].pe;
    newEntry.line = cmd.line;
    newEntry.data = hold[cmd.line].data;
  end

  // Silo storage
  always_ff @(posedge clk) begin
    if (cmd.write) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.write) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop)   rdPtr <= rdPtr + 1'b1;
      case ({cmd.write, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full      = (count == DEPTH_CNT);
  assign headEntry = mem[rdPtr];

endmodule

// File: rtl/rx_silo_ctrl.sv
`timescale 1ns/1ps
module rx_silo_ctrl
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [15:0]                busWdata,
  input  logic [NUM_LINES-1:0]       pendVec,
  input  logic [CNT_W-1:0]           count,
  input  logic                       full,
  output siloCmdT                    cmd,
  output logic                       captureEn,
  output logic [15:0]                csrWord,
  output logic                       rxIrq,
  output logic                       alarmIrq,
  output logic [NUM_LINES*CFG_W-1:0] lineCfg,
  output logic [NUM_LINES*2-1:0]     lenCode
);

  localparam logic [CNT_W-1:0] ALARM_CNT = CNT_W'(ALARM_LEVEL);

  logic              scanEn, rxIe, alarmIe;
  logic              csrWr, cfgWr, clrReq, bufRd;
  logic              dropPend, alarmArmed, alarmPend;
  logic [CFG_W-1:0]  cfg [NUM_LINES];
  logic              anyPend;
  logic [LINE_W-1:0] selLine;
  logic              unusedHi;

  assign unusedHi = ^busWdata[15:13];
  assign csrWr    = busWr && !busSel;
  assign cfgWr    = busWr && busSel;
  assign clrReq   = csrWr && busWdata[4];
  assign bufRd    = busRd && busSel;

  // Control/status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanEn <= 1'b0; rxIe <= 1'b0; alarmIe <= 1'b0;
    end else if (clrReq) begin
      scanEn <= 1'b0; rxIe <= 1'b0; alarmIe <= 1'b0;
    end else if (csrWr) begin
      scanEn  <= busWdata[5];
      rxIe    <= busWdata[6];
      alarmIe <= busWdata[12];
    end
  end

  // Per-line configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || clrReq) begin
      for (int i = 0; i < NUM_LINES; i++) cfg[i] <= '0;
    end else if (cfgWr) begin
      cfg[busWdata[LINE_W-1:0]] <= busWdata[11:3];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfgOut
    assign lineCfg[g*CFG_W +: CFG_W] = cfg[g];
    assign lenCode[g*2 +: 2]         = cfg[g][1:0];
  end

  // Fixed-priority retire: lowest pending line wins
  always_comb begin
    selLine = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pendVec[i]) selLine = LINE_W'(i);
    end
  end
  assign anyPend = |pendVec;

  always_comb begin
    cmd        = '0;
    cmd.clear  = clrReq;
    cmd.retire = anyPend && !clrReq;
    cmd.write  = anyPend && !clrReq && !full;
    cmd.line   = selLine;
    cmd.ovr    = dropPend;
    cmd.pop    = bufRd && (count != '0) && !clrReq;
  end

  // Overrun carried to the next stored entry after a drop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dropPend <= 1'b0;
    else if (clrReq)          dropPend <= 1'b0;
    else if (cmd.retire && full) dropPend <= 1'b1;
    else if (cmd.write)       dropPend <= 1'b0;
  end

  // Alarm latch with re-arm below threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmArmed <= 1'b1;
      alarmPend  <= 1'b0;
    end else if (clrReq) begin
      alarmArmed <= 1'b1;
      alarmPend  <= 1'b0;
    end else begin
      if (alarmArmed && count >= ALARM_CNT) begin
        alarmPend  <= 1'b1;
        alarmArmed <= 1'b0;
      end else begin
        if (bufRd) alarmPend <= 1'b0;
        if (!alarmArmed && count < ALARM_CNT) alarmArmed <= 1'b1;
      end
    end
  end

  assign captureEn = scanEn;
  assign csrWord   = {3'b000, alarmIe, 5'b00000, rxIe, scanEn, 5'b00000};
  assign rxIrq     = rxIe && (count != '0);
  assign alarmIrq  = alarmIe && alarmPend;

endmodule

// File: rtl/rx_silo.sv
`timescale 1ns/1ps
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LINES-1:0]       rxStrobe,
  input  logic [NUM_LINES*8-1:0]     rxData,
  input  logic [NUM_LINES-1:0]       rxParErr,
  input  logic [NUM_LINES-1:0]       rxFrmErr,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [15:0]                busWdata,
  output logic [15:0]                busRdata,
  output logic                       rxIrq,
  output logic                       alarmIrq,
  output logic [NUM_LINES*CFG_W-1:0] lineCfg
);

  siloCmdT                siloCmd;
  logic                   captureEn;
  logic [NUM_LINES-1:0]   pendVec;
  logic [CNT_W-1:0]       siloCount;
  logic                   siloFull;
  siloEntryT              headEntry;
  logic [15:0]            csrWord;
  logic [NUM_LINES*2-1:0] lenCode;
  logic [15:0]            bufWord;

  rx_silo_ctrl #(
    .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .pendVec(pendVec), .count(siloCount), .full(siloFull),
    .cmd(siloCmd), .captureEn(captureEn), .csrWord(csrWord), .rxIrq(rxIrq),
    .alarmIrq(alarmIrq), .lineCfg(lineCfg), .lenCode(lenCode)
  );

  rx_silo_dp #(
    .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cmd(siloCmd), .captureEn(captureEn),
    .rxStrobe(rxStrobe), .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .lenCode(lenCode), .pendVec(pendVec), .count(siloCount), .full(siloFull),
    .headEntry(headEntry)
  );

  always_comb begin
    bufWord = '0;
    if (siloCount != '0)
      bufWord = {1'b1, headEntry.ovr, headEntry.fe, headEntry.pe, 1'b0,
                 headEntry.line, headEntry.data};
  end

  assign busRdata = busSel ? bufWord : csrWord;

endmodule

// File: rtl/rx_silo_chk.sv
`timescale 1ns/1ps
module rx_silo_chk #(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  parameter int CNT_W       = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic [15:0]          busRdata,
  input logic                 rxIrq,
  input logic                 alarmIrq,
  input logic [CNT_W-1:0]     count,
  input logic [NUM_LINES-1:0] pendVec,
  input logic                 scanEn,
  input logic                 clearReq
);

  // R2
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busRdata[15]) |-> (busRdata == 16'h0000));

  // R11
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busRdata[15]) |-> !rxIrq);

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R10
  alarm_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> ($past(count) >= CNT_W'(ALARM_LEVEL)));

  // R7
  scan_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && pendVec == '0 && count == '0) |=> (count == '0));

  // R12
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (count == '0 && pendVec == '0 && !alarmIrq));

endmodule

bind rx_silo rx_silo_chk #(
  .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busRdata(busRdata), .rxIrq(rxIrq),
  .alarmIrq(alarmIrq), .count(siloCount), .pendVec(pendVec), .scanEn(captureEn),
  .clearReq(siloCmd.clear)
);

// File: tb/test_rx_silo.sv
`timescale 1ns/1ps
module test_rx_silo;

  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] rxStrobe = '0;
  logic [NL*8-1:0] rxData = '0;
  logic [NL-1:0] rxParErr = '0;
  logic [NL-1:0] rxFrmErr = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [15:0]   busWdata = '0;
  logic [15:0]   busRdata;
  logic          rxIrq, alarmIrq;
  logic [NL*9-1:0] lineCfg;

  int nErr = 0;
  int nChecks = 0;
  logic [15:0] expQ[$];

  always #2 clk = ~clk;

  rx_silo i_rx_silo (
    .clk(clk), .rstN(rstN), .rxStrobe(rxStrobe), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .rxIrq(rxIrq),
    .alarmIrq(alarmIrq), .lineCfg(lineCfg)
  );

  function automatic logic [15:0] expWord(int line, logic [7:0] d, logic pe,
                                          logic fe, logic ovr, int len);
    logic [7:0] m;
    m = (len == 0) ? 8'h1F : (len == 1) ? 8'h3F : (len == 2) ? 8'h7F : 8'hFF;
    return {1'b1, ovr, fe, pe, 1'b0, 3'(line), d & m};
  endfunction

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic sel, logic [15:0] d);
    @(negedge clk);
    busSel = sel; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readBuf(output logic [15:0] w);
    @(negedge clk);
    busSel = 1'b1; busRd = 1'b1;
    #1 w = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic peekCsr(output logic [15:0] w);
    @(negedge clk);
    busSel = 1'b0;
    #1 w = busRdata;
  endtask

  task automatic strobe(int line, logic [7:0] d, logic pe, logic fe);
    @(negedge clk);
    rxStrobe = '0; rxStrobe[line] = 1'b1;
    rxData[line*8 +: 8] = d;
    rxParErr[line] = pe; rxFrmErr[line] = fe;
    @(negedge clk);
    rxStrobe = '0; rxParErr = '0; rxFrmErr = '0;
  endtask

  task automatic setup();
    busWrite(1'b0, 16'h1060);
    for (int l = 0; l < NL; l++) busWrite(1'b1, 16'(3 << 3) | 16'(l));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [15:0] w;
    int unsigned seed;
    seed = $urandom(32'd4711);

    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    busSel = 1'b1;
    #1 check("R1 buffer", busRdata, 0);
    check("R1 irqs", {rxIrq, alarmIrq}, 0);
    check("R1 lineCfg", lineCfg, 0);
    peekCsr(w);
    check("R1 csr", w, 0);

    // R13 control readback
    busWrite(1'b0, 16'hFFEF);
    peekCsr(w);
    check("R13 csr bits", w, 16'h1060);
    setup();

    // R6 configuration write, other lines untouched
    busWrite(1'b1, 16'h0EFA);
    check("R6 line2", lineCfg[2*9 +: 9], 9'(16'h0EFA >> 3));
    check("R6 line1", lineCfg[1*9 +: 9], 9'd3);
    check("R6 line3", lineCfg[3*9 +: 9], 9'd3);
    busWrite(1'b1, 16'h0018 | 16'd2);

    // R2 / R11 single character
    strobe(5, 8'hA5, 1'b1, 1'b0);
    waitCycles(1);
    check("R11 rxIrq set", rxIrq, 1);
    readBuf(w);
    check("R2 word", w, expWord(5, 8'hA5, 1, 0, 0, 3));
    check("R11 rxIrq clear", rxIrq, 0);
    strobe(2, 8'h3C, 1'b0, 1'b1);
    waitCycles(1);
    readBuf(w);
    check("R2 frame flag", w, expWord(2, 8'h3C, 0, 1, 0, 3));

    // R4 simultaneous strobes
    @(negedge clk);
    rxStrobe = 8'b0100_1010;
    rxData[6*8 +: 8] = 8'h66; rxData[1*8 +: 8] = 8'h11; rxData[3*8 +: 8] = 8'h33;
    @(negedge clk);
    rxStrobe = '0;
    waitCycles(4);
    readBuf(w); check("R4 first", w, expWord(1, 8'h11, 0, 0, 0, 3));
    readBuf(w); check("R4 second", w, expWord(3, 8'h33, 0, 0, 0, 3));
    readBuf(w); check("R4 third", w, expWord(6, 8'h66, 0, 0, 0, 3));

    // R5 length masks
    for (int len = 0; len < 3; len++) begin
      busWrite(1'b1, 16'(len << 3));
      strobe(0, 8'hFF, 1'b0, 1'b0);
      waitCycles(1);
      readBuf(w);
      check($sformatf("R5 len%0d", len), w, expWord(0, 8'hFF, 0, 0, 0, len));
    end
    busWrite(1'b1, 16'h0018);

    // R9 held character replaced
    @(negedge clk);
    rxStrobe = '1;
    for (int l = 0; l < NL; l++) rxData[l*8 +: 8] = 8'(8'h10 + l);
    @(negedge clk);
    rxStrobe = 8'h80; rxData[7*8 +: 8] = 8'h77;
    @(negedge clk);
    rxStrobe = '0;
    waitCycles(10);
    for (int l = 0; l < 7; l++) begin
      readBuf(w);
      check("R9 clean lines", w, expWord(l, 8'(8'h10 + l), 0, 0, 0, 3));
    end
    readBuf(w);
    check("R9 replaced", w, expWord(7, 8'h77, 0, 0, 1, 3));
    readBuf(w);
    check("R2 empty after drain", w, 0);

    // R3 random bursts
    for (int b = 0; b < 20; b++) begin
      int k;
      k = 1 + int'($urandom_range(11, 0));
      for (int j = 0; j < k; j++) begin
        int l;
        logic [7:0] d;
        logic pe, fe;
        l = int'($urandom_range(7, 0));
        d = 8'($urandom);
        pe = 1'($urandom); fe = 1'($urandom);
        strobe(l, d, pe, fe);
        expQ.push_back(expWord(l, d, pe, fe, 0, 3));
      end
      waitCycles(2);
      while (expQ.size() > 0) begin
        logic [15:0] e;
        e = expQ.pop_front();
        readBuf(w);
        check("R3 order", w, e);
      end
      readBuf(w);
      check("R3 drained", w, 0);
    end

    // R10 alarm
    busWrite(1'b0, 16'h0010);
    setup();
    for (int j = 0; j < 15; j++) strobe(0, 8'(j), 0, 0);
    waitCycles(3);
    check("R10 below level", alarmIrq, 0);
    strobe(0, 8'd15, 0, 0);
    waitCycles(3);
    check("R10 at level", alarmIrq, 1);
    strobe(0, 8'd16, 0, 0);
    waitCycles(2);
    readBuf(w);
    waitCycles(3);
    check("R10 no refire at 16", alarmIrq, 0);
    readBuf(w);
    waitCycles(3);
    strobe(0, 8'd17, 0, 0);
    waitCycles(3);
    check("R10 rearmed", alarmIrq, 1);

    // R12 clear
    busWrite(1'b0, 16'h1070);
    busSel = 1'b1;
    #1 check("R12 buffer empty", busRdata, 0);
    check("R12 irqs", {rxIrq, alarmIrq}, 0);
    check("R12 lineCfg", lineCfg, 0);
    peekCsr(w);
    check("R12 csr", w, 0);

    // R8 full and overrun tagging
    setup();
    for (int j = 0; j < 64; j++) strobe(0, 8'(j), 0, 0);
    for (int j = 0; j < 3; j++) strobe(0, 8'hEE, 0, 0);
    waitCycles(3);
    begin
      int bad;
      bad = 0;
      for (int j = 0; j < 64; j++) begin
        readBuf(w);
        if (w !== expWord(0, 8'(j), 0, 0, 0, 3)) bad++;
      end
      check("R8 sixty-four kept", bad, 0);
    end
    readBuf(w);
    check("R8 extras dropped", w, 0);
    strobe(4, 8'h42, 0, 0);
    waitCycles(1);
    readBuf(w);
    check("R8 overrun on next", w, 16'hC442);

    // R7 scan disabled
    busWrite(1'b0, 16'h0040);
    strobe(3, 8'h33, 0, 0);
    waitCycles(3);
    busSel = 1'b1;
    #1 check("R7 ignored", busRdata, 0);
    check("R7 no irq", rxIrq, 0);
    busWrite(1'b0, 16'h1060);
    strobe(3, 8'h34, 0, 0);
    waitCycles(1);
    readBuf(w);
    check("R7 resumed", w, expWord(3, 8'h34, 0, 0, 0, 3));

    finishRun();
  end

endmodule